// File: doc/BRIEF.md
# Frame DMA Control Register File

This block is the processor-facing register set of a bridge that moves serial-storage frames between system memory and a link-layer core. The processor uses a simple single-cycle bus with word-aligned byte addresses. On it, the processor sets three memory base addresses: one for outgoing frames, one for incoming non-data frames and one for incoming data frames. It also writes a control word that sets the outgoing length and frame kind, starts a transmission or resets the datapaths. Finally it writes a clear word that acknowledges interrupts.

A read does not reach the register that a write to the same offset reaches. Reads return the link core's error code and a receive status word. The status word packs a running count of received words and a flag that marks the last received frame as a non-data frame. The count and the flag each have their own clear rule. Two sticky flags, one for each direction, tell the processor that a frame finished. Each flag is set by a done pulse from its datapath and is cleared from software.

Top module: `fis_dma_regs`

## Requirements
- R1: After reset, all three address outputs read zero. The transmit length and the data-kind select are zero, both pulses and both interrupt flags are low, and `bus_rdata` is zero.
- R2: A write to offset 0x00 loads the transmit base, 0x04 loads the non-data receive base and 0x0C loads the data receive base. Bits [8:0] of each stored base are forced to zero, and the new value is visible at the output in the cycle after the write.
- R3: A write to offset 0x08 loads `tx_is_data` from bit 29 (1 means data frame) and `tx_words` from bits [15:0]. Both hold until the next write to 0x08.
- R4: In the cycle after a write to 0x08, `dp_soft_rst` equals bit 31 and `tx_start` equals bit 30 of that write. Each pulse lasts one cycle and is low afterwards unless another 0x08 write asks for it.
- R5: A read at 0x04 returns `err_code`. A read at 0x0C returns the status word: received-frame kind in bit 31 (1 means non-data) and the received word count in the low CNT_W bits (bits [23:0] by default), with the other bits zero. `bus_rdata` changes only in the cycle after a read strobe.
- R6: Each `rx_beat` cycle adds one to the received word count. The count saturates at its all-ones value.
- R7: Any write to 0x08 clears the received word count. When the clear and `rx_beat` arrive in the same cycle, the clear wins.
- R8: `rx_done` loads the frame-kind flag from `rx_nondata`. Writing 1 to bit 29 at offset 0x10 clears the flag. When both arrive in the same cycle, the load wins.
- R9: `rx_done` sets `irq_rx` and `tx_done` sets `irq_tx`. Writing 1 to bit 31 at offset 0x10 clears `irq_rx`, and writing 1 to bit 30 clears `irq_tx`. When a set and a clear arrive in the same cycle, the set wins.
- R10: Writes to any other address, including unaligned ones, change no output. Reads of 0x00, 0x08, 0x10 and any other non-readable address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DW | Read data, valid the cycle after `bus_rd` |
| err_code | input | DW | Error code from the link core |
| rx_beat | input | 1 | One received word stored this cycle |
| rx_done | input | 1 | Receive frame finished |
| rx_nondata | input | 1 | Kind of the finished frame, 1 = non-data |
| tx_done | input | 1 | Transmit frame finished |
| tx_base | output | DW | Transmit frame base address |
| rx_nd_base | output | DW | Non-data receive base address |
| rx_d_base | output | DW | Data receive base address |
| tx_words | output | TXW | Transmit length in words |
| tx_is_data | output | 1 | Transmit frame is a data frame |
| tx_start | output | 1 | One-cycle transmit start pulse |
| dp_soft_rst | output | 1 | One-cycle datapath reset pulse |
| irq_rx | output | 1 | Sticky receive-done interrupt |
| irq_tx | output | 1 | Sticky transmit-done interrupt |

## Verification
The word-count saturation is the hardest case to reach from the ports, because with the default width it takes sixteen million beats. The bench therefore builds the block with an 8-bit count and streams more than 255 beats before it reads the status. The same-cycle collisions are driven in a single cycle: a control write with a beat, a clear write with a done pulse, and a kind clear with a kind load. The bench then reads the result back through the status read, or observes the interrupt pins.

// File: rtl/fisreg_pkg.sv
package fisreg_pkg;

    // write-side register map (byte offsets)
    localparam logic [7:0] OFF_TXB  = 8'h00;
    localparam logic [7:0] OFF_RXNB = 8'h04;
    localparam logic [7:0] OFF_CTL  = 8'h08;
    localparam logic [7:0] OFF_RXDB = 8'h0C;
    localparam logic [7:0] OFF_ACK  = 8'h10;

    // read-side register map (byte offsets)
    localparam logic [7:0] OFF_ERR  = 8'h04;
    localparam logic [7:0] OFF_STAT = 8'h0C;

    // control word fields
    localparam int unsigned CTL_RST_BIT  = 31;
    localparam int unsigned CTL_GO_BIT   = 30;
    localparam int unsigned CTL_DATA_BIT = 29;

    // acknowledge word fields
    localparam int unsigned ACK_RXIRQ_BIT = 31;
    localparam int unsigned ACK_TXIRQ_BIT = 30;
    localparam int unsigned ACK_KIND_BIT  = 29;

    // status word fields
    localparam int unsigned STAT_KIND_BIT = 31;

    // base addresses are aligned to this many low zero bits
    localparam int unsigned BASE_ALIGN = 9;

    // interrupt flag indices
    localparam int unsigned IRQ_RX = 0;
    localparam int unsigned IRQ_TX = 1;
    localparam int unsigned NUM_IRQ = 2;

    typedef enum logic [2:0] {
        WSEL_NONE,
        WSEL_TXB,
        WSEL_RXNB,
        WSEL_CTL,
        WSEL_RXDB,
        WSEL_ACK
    } wsel_e;

    typedef enum logic [1:0] {
        RSEL_ZERO,
        RSEL_ERR,
        RSEL_STAT
    } rsel_e;

endpackage

// File: rtl/fisreg_wr_decode.sv
module fisreg_wr_decode
    import fisreg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DW     = 32,
    parameter int unsigned TXW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     tx_base,
    output logic [DW-1:0]     rx_nd_base,
    output logic [DW-1:0]     rx_d_base,
    output logic [TXW-1:0]    tx_words,
    output logic              tx_is_data,
    output logic              tx_start,
    output logic              dp_soft_rst,
    output logic              ctl_wr,
    output logic [2:0]        ack_bits
);

    localparam int unsigned BW = DW - BASE_ALIGN;

    typedef struct packed {
        logic [BW-1:0]  txb;
        logic [BW-1:0]  rxnb;
        logic [BW-1:0]  rxdb;
        logic [TXW-1:0] words;
        logic           is_data;
        logic           go;
        logic           srst;
    } wr_state_t;

    wr_state_t s_d, s_q;
    wsel_e     wsel;

    always_comb begin
        wsel = WSEL_NONE;
        if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_TXB))       wsel = WSEL_TXB;
            else if (bus_addr == ADDR_W'(OFF_RXNB)) wsel = WSEL_RXNB;
            else if (bus_addr == ADDR_W'(OFF_CTL))  wsel = WSEL_CTL;
            else if (bus_addr == ADDR_W'(OFF_RXDB)) wsel = WSEL_RXDB;
            else if (bus_addr == ADDR_W'(OFF_ACK))  wsel = WSEL_ACK;
            else                                    wsel = WSEL_NONE;
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.go   = 1'b0;
        s_d.srst = 1'b0;
        case (wsel)
            WSEL_TXB:  s_d.txb  = bus_wdata[DW-1:BASE_ALIGN];
            WSEL_RXNB: s_d.rxnb = bus_wdata[DW-1:BASE_ALIGN];
            WSEL_RXDB: s_d.rxdb = bus_wdata[DW-1:BASE_ALIGN];
            WSEL_CTL: begin
                s_d.words   = bus_wdata[TXW-1:0];
                s_d.is_data = bus_wdata[CTL_DATA_BIT];
                s_d.go      = bus_wdata[CTL_GO_BIT];
                s_d.srst    = bus_wdata[CTL_RST_BIT];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_base     = {s_q.txb,  {BASE_ALIGN{1'b0}}};
    assign rx_nd_base  = {s_q.rxnb, {BASE_ALIGN{1'b0}}};
    assign rx_d_base   = {s_q.rxdb, {BASE_ALIGN{1'b0}}};
    assign tx_words    = s_q.words;
    assign tx_is_data  = s_q.is_data;
    assign tx_start    = s_q.go;
    assign dp_soft_rst = s_q.srst;
    assign ctl_wr      = (wsel == WSEL_CTL);
    assign ack_bits    = (wsel == WSEL_ACK) ?
                         {bus_wdata[ACK_RXIRQ_BIT], bus_wdata[ACK_TXIRQ_BIT], bus_wdata[ACK_KIND_BIT]} :
                         3'b000;

    // R2: base written at 0x00 appears aligned in the next cycle
    p_txbase_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_TXB)) |=>
        (tx_base == {$past(bus_wdata[DW-1:BASE_ALIGN]), {BASE_ALIGN{1'b0}}}));

    // R4: a start pulse only follows a control write with the start bit
    p_go_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_CTL) && bus_wdata[CTL_GO_BIT]));

    // R4: a reset pulse only follows a control write with the reset bit
    p_rst_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dp_soft_rst |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_CTL) && bus_wdata[CTL_RST_BIT]));

    // R10: a write that decodes to nothing leaves every register unchanged
    p_undecoded_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wsel == WSEL_NONE) |=>
        ($stable(tx_base) && $stable(rx_nd_base) && $stable(rx_d_base) &&
         $stable(tx_words) && $stable(tx_is_data)));

endmodule

// File: rtl/fisreg_rx_status.sv
module fisreg_rx_status #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_beat,
    input  logic             rx_done,
    input  logic             rx_nondata,
    input  logic             cnt_clr,
    input  logic             kind_clr,
    output logic [CNT_W-1:0] rx_count,
    output logic             rx_kind
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             kind;
    } rx_state_t;

    rx_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // count: clear has priority, then saturating increment
        if (cnt_clr)
            r_d.cnt = '0;
        else if (rx_beat && r_q.cnt != CNT_MAX)
            r_d.cnt = r_q.cnt + 1'b1;
        // kind flag: load on frame end has priority over clear
        if (rx_done)
            r_d.kind = rx_nondata;
        else if (kind_clr)
            r_d.kind = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_count = r_q.cnt;
    assign rx_kind  = r_q.kind;

    // R7: control write empties the count
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (rx_count == '0));

    // R6: a saturated count stays saturated
    p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CNT_MAX && !cnt_clr) |=> (rx_count == CNT_MAX));

    // R6: without beat or clear the count holds
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_beat && !cnt_clr) |=> $stable(rx_count));

    // R8: frame end loads the kind flag even under a clear
    p_kind_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (rx_kind == $past(rx_nondata)));

endmodule

// File: rtl/fisreg_irq.sv
module fisreg_irq #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    logic [N-1:0] flag_d, flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_comb begin
            if (set_i[g])      flag_d[g] = 1'b1;
            else if (clr_i[g]) flag_d[g] = 1'b0;
            else               flag_d[g] = flag_q[g];
        end

        // R9: a done pulse always leaves its flag set
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_o[g]);

        // R9: a lone clear drops the flag
        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/fis_dma_regs.sv
module fis_dma_regs
    import fisreg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DW     = 32,
    parameter int unsigned TXW    = 16,
    parameter int unsigned CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     err_code,
    input  logic              rx_beat,
    input  logic              rx_done,
    input  logic              rx_nondata,
    input  logic              tx_done,
    output logic [DW-1:0]     tx_base,
    output logic [DW-1:0]     rx_nd_base,
    output logic [DW-1:0]     rx_d_base,
    output logic [TXW-1:0]    tx_words,
    output logic              tx_is_data,
    output logic              tx_start,
    output logic              dp_soft_rst,
    output logic              irq_rx,
    output logic              irq_tx
);

    localparam int unsigned STAT_PAD = DW - 1 - CNT_W;

    logic             ctl_wr;
    logic [2:0]       ack_bits;
    logic [CNT_W-1:0] rx_count;
    logic             rx_kind;
    logic [NUM_IRQ-1:0] irq_set, irq_clr, irq_flag;

    fisreg_wr_decode #(
        .ADDR_W (ADDR_W),
        .DW     (DW),
        .TXW    (TXW)
    ) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .tx_base     (tx_base),
        .rx_nd_base  (rx_nd_base),
        .rx_d_base   (rx_d_base),
        .tx_words    (tx_words),
        .tx_is_data  (tx_is_data),
        .tx_start    (tx_start),
        .dp_soft_rst (dp_soft_rst),
        .ctl_wr      (ctl_wr),
        .ack_bits    (ack_bits)
    );

    fisreg_rx_status #(
        .CNT_W (CNT_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_beat    (rx_beat),
        .rx_done    (rx_done),
        .rx_nondata (rx_nondata),
        .cnt_clr    (ctl_wr),
        .kind_clr   (ack_bits[0]),
        .rx_count   (rx_count),
        .rx_kind    (rx_kind)
    );

    always_comb begin
        irq_set         = '0;
        irq_clr         = '0;
        irq_set[IRQ_RX] = rx_done;
        irq_set[IRQ_TX] = tx_done;
        irq_clr[IRQ_RX] = ack_bits[2];
        irq_clr[IRQ_TX] = ack_bits[1];
    end

    fisreg_irq #(
        .N (NUM_IRQ)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (irq_clr),
        .flag_o (irq_flag)
    );

    assign irq_rx = irq_flag[IRQ_RX];
    assign irq_tx = irq_flag[IRQ_TX];

    // read path: registered, updated only on a read strobe
    rsel_e         rsel;
    logic [DW-1:0] rdata_d, rdata_q, stat_word;

    always_comb begin
        stat_word = {rx_kind, {STAT_PAD{1'b0}}, rx_count};
        rsel      = RSEL_ZERO;
        if (bus_addr == ADDR_W'(OFF_ERR))       rsel = RSEL_ERR;
        else if (bus_addr == ADDR_W'(OFF_STAT)) rsel = RSEL_STAT;
        rdata_d = rdata_q;
        if (bus_rd) begin
            case (rsel)
                RSEL_ERR:  rdata_d = err_code;
                RSEL_STAT: rdata_d = stat_word;
                default:   rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    // R10: reads of non-readable addresses return zero
    p_zero_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != ADDR_W'(OFF_ERR) && bus_addr != ADDR_W'(OFF_STAT)) |=>
        (bus_rdata == '0));

    // R5: read data holds without a read strobe
    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R5: error code read returns the input sampled with the strobe
    p_err_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_ERR)) |=> (bus_rdata == $past(err_code)));

endmodule

// File: tb/sim_fis_dma_regs.sv
module sim_fis_dma_regs;

    localparam int unsigned AW = 8;
    localparam int unsigned DW = 32;
    localparam int unsigned TW = 16;
    localparam int unsigned CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] err_code = '0;
    logic          rx_beat = 1'b0;
    logic          rx_done = 1'b0;
    logic          rx_nondata = 1'b0;
    logic          tx_done = 1'b0;
    logic [DW-1:0] tx_base, rx_nd_base, rx_d_base;
    logic [TW-1:0] tx_words;
    logic          tx_is_data, tx_start, dp_soft_rst, irq_rx, irq_tx;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    fis_dma_regs #(.ADDR_W(AW), .DW(DW), .TXW(TW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .err_code(err_code), .rx_beat(rx_beat), .rx_done(rx_done),
        .rx_nondata(rx_nondata), .tx_done(tx_done), .tx_base(tx_base),
        .rx_nd_base(rx_nd_base), .rx_d_base(rx_d_base), .tx_words(tx_words),
        .tx_is_data(tx_is_data), .tx_start(tx_start), .dp_soft_rst(dp_soft_rst),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] e_tx;
        logic [31:0] e_rxn;
        logic [31:0] e_rxd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 32'h1234_5FFF, 32'h1234_5E00, 32'h0000_0000, 32'h0000_0000},
        '{8'h04, 32'hFFFF_FFFF, 32'h1234_5E00, 32'hFFFF_FE00, 32'h0000_0000},
        '{8'h0C, 32'h8000_01FF, 32'h1234_5E00, 32'hFFFF_FE00, 32'h8000_0000},
        '{8'h14, 32'hFFFF_FFFF, 32'h1234_5E00, 32'hFFFF_FE00, 32'h8000_0000},
        '{8'h00, 32'h0000_0200, 32'h0000_0200, 32'hFFFF_FE00, 32'h8000_0000},
        '{8'h02, 32'hFFFF_FFFF, 32'h0000_0200, 32'hFFFF_FE00, 32'h8000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write: returns at the negedge after the capturing edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_base", tx_base, 0);
        chk("R1 rx_nd_base", rx_nd_base, 0);
        chk("R1 rx_d_base", rx_d_base, 0);
        chk("R1 ctl", {tx_is_data, tx_start, dp_soft_rst, irq_rx, irq_tx, 11'd0, tx_words}, 0);
        chk("R1 rdata", bus_rdata, 0);

        // R2 / R10 vector table
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].addr, VECS[i].data);
            chk("R2 tx_base", tx_base, VECS[i].e_tx);
            chk("R2 rx_nd_base", rx_nd_base, VECS[i].e_rxn);
            chk("R2 rx_d_base", rx_d_base, VECS[i].e_rxd);
        end

        // R3 / R4 control with both pulses
        wr(8'h08, 32'hE000_ABCD);
        chk("R4 start pulse", {31'd0, tx_start}, 1);
        chk("R4 reset pulse", {31'd0, dp_soft_rst}, 1);
        chk("R3 words", {16'd0, tx_words}, 32'h0000_ABCD);
        chk("R3 is_data", {31'd0, tx_is_data}, 1);
        @(negedge clk);
        chk("R4 pulses end", {30'd0, tx_start, dp_soft_rst}, 0);
        chk("R3 words hold", {16'd0, tx_words}, 32'h0000_ABCD);
        wr(8'h08, 32'h0000_0005);
        chk("R4 no pulses", {30'd0, tx_start, dp_soft_rst}, 0);
        chk("R3 words+kind", {15'd0, tx_is_data, tx_words}, 32'h0000_0005);
        // R10 undecoded write keeps control
        wr(8'h18, 32'hFFFF_FFFF);
        chk("R10 ctl kept", {15'd0, tx_is_data, tx_words}, 32'h0000_0005);

        // R5 reads
        err_code = 32'hDEAD_BEEF;
        rd(8'h04, r); chk("R5 err read", r, 32'hDEAD_BEEF);
        @(negedge clk); chk("R5 rdata hold", bus_rdata, 32'hDEAD_BEEF);
        rd(8'h00, r); chk("R10 read 0x00", r, 0);
        rd(8'h08, r); chk("R10 read 0x08", r, 0);
        rd(8'h10, r); chk("R10 read 0x10", r, 0);

        // R6 counting
        rx_beat = 1'b1; repeat (5) @(negedge clk); rx_beat = 1'b0;
        rd(8'h0C, r); chk("R6 count 5", r, 5);
        // R7 clear
        wr(8'h08, 32'h0);
        rd(8'h0C, r); chk("R7 count cleared", r, 0);
        rx_beat = 1'b1; repeat (3) @(negedge clk);
        wr(8'h08, 32'h0);   // beat still high during the write
        rx_beat = 1'b0;
        rd(8'h0C, r); chk("R7 clear beats beat", r, 0);
        // R6 saturation
        rx_beat = 1'b1; repeat (260) @(negedge clk); rx_beat = 1'b0;
        rd(8'h0C, r); chk("R6 saturate", r, 32'h0000_00FF);
        wr(8'h08, 32'h0);

        // R8 / R9 receive done
        rx_done = 1'b1; rx_nondata = 1'b1; @(negedge clk); rx_done = 1'b0; rx_nondata = 1'b0;
        chk("R9 irq_rx set", {31'd0, irq_rx}, 1);
        rd(8'h0C, r); chk("R8 kind set", r, 32'h8000_0000);
        wr(8'h10, 32'h2000_0000);
        rd(8'h0C, r); chk("R8 kind cleared", r, 0);
        chk("R9 irq_rx kept", {31'd0, irq_rx}, 1);
        // R8 load wins over clear
        rx_done = 1'b1; rx_nondata = 1'b1;
        wr(8'h10, 32'h2000_0000);
        rx_done = 1'b0; rx_nondata = 1'b0;
        rd(8'h0C, r); chk("R8 load wins", r, 32'h8000_0000);
        wr(8'h10, 32'h8000_0000);
        chk("R9 irq_rx cleared", {31'd0, irq_rx}, 0);

        // R9 transmit done and set-wins
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        chk("R9 irq_tx set", {31'd0, irq_tx}, 1);
        tx_done = 1'b1;
        wr(8'h10, 32'h4000_0000);
        tx_done = 1'b0;
        chk("R9 set wins", {31'd0, irq_tx}, 1);
        wr(8'h10, 32'h4000_0000);
        chk("R9 irq_tx cleared", {31'd0, irq_tx}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule